// File: doc/BRIEF.md
# Transmit Link Error Collector and Reinit Controller

This block gathers the error events of a serial transmit link into one sticky status word, raises a level interrupt for the bits software has enabled, and can start a link reinitialization either on its own (when an enabled error first appears) or on a software request. Software clears a status bit by writing a one to it. Each error bit has two separate enables: one that routes it to the interrupt and one that lets it start an automatic reinit.

Sixteen per-lane inputs are folded into single events. One is a transceiver ready vector, where any lane falling while the link is up counts as an error. The other is a FIFO-full vector, where any lane reporting full while the link is up counts as an error. Three valid/ready pairs are watched for a protocol violation. The rule is that a consumer raising ready expects valid in the same cycle. So a cycle with ready high and valid low is an error, and a cycle with ready low carries no obligation. The block does not sequence the datapath reset. It only holds `reinit_active` high for a fixed window, during which the datapath performs its reinit.

Registers sit on a 9-bit single-cycle bus. A write happens on a clock edge with `reg_wr` high. Reads are combinational from `reg_addr`.

Top module: `lnk_err_ctrl`

## Requirements
- R1: Status register (address 0) bit positions: 8 gearbox overflow, 7 gearbox underflow, 5 lane FIFO full, 4 lane ready dropped, 3 command valid/ready violation, 2 frame-data violation, 1 link-data violation, 0 SYSREF period error. An event in a cycle sets its bit at that cycle's clock edge, and the bit stays set.
- R2: Writing address 0 clears exactly the bits written as one. Bits written as zero keep their value. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R3: Bit 6 of addresses 0, 1 and 2 always reads zero, and writes to it have no effect. Address 3 holds only bits 1:0, and its other bits read zero.
- R4: Bit 4 sets when any lane of `lane_rdy` goes from 1 to 0 between two consecutive cycles while `link_up` is high. The previous lane sample is all zeros after reset. A drop while `link_up` is low, or a rising lane, sets nothing.
- R5: Bit 5 sets in any cycle in which `link_up` is high and any lane of `lane_full` is 1. While `link_up` is low it sets nothing.
- R6: Bits 3, 2 and 1 set in a cycle where their ready input is high and their valid input is low. Ready low, or valid and ready both high, sets nothing.
- R7: After reset, the interrupt enable register (address 1) reads 0x1B1, the reinit enable register (address 2) reads 0x000, and the status register reads 0x000.
- R8: `irq` is high exactly when some status bit and the same bit of the interrupt enable register are both one.
- R9: When an event sets a status bit that was zero, and that bit's reinit enable is one, `reinit_active` rises at that edge and stays high for exactly REINIT_CYCLES cycles.
- R10: Triggers that occur while `reinit_active` is high neither extend nor restart the window. They set their status bits only.
- R11: Writing one to bit 0 of address 3 sets a pending request, and bit 0 reads that request. The request starts the reinit window at the first edge where `reinit_active` is low, and it clears at that edge. A write of one during a window keeps the request pending until the window ends.
- R12: Bit 1 of address 3 reads the value of `reinit_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is running; qualifies the lane events |
| gb_ovf_pulse | input | 1 | Gearbox overflow event |
| gb_unf_pulse | input | 1 | Gearbox underflow event |
| lemc_err_pulse | input | 1 | SYSREF period mismatch event |
| cmd_valid | input | 1 | Command channel valid |
| cmd_ready | input | 1 | Command channel ready |
| fdata_valid | input | 1 | Frame data valid |
| fdata_ready | input | 1 | Frame data ready |
| ldata_valid | input | 1 | Link data valid |
| ldata_ready | input | 1 | Link data ready |
| lane_rdy | input | NUM_LANES | Per-lane transceiver ready |
| lane_full | input | NUM_LANES | Per-lane FIFO full flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data |
| irq | output | 1 | Level interrupt |
| reinit_active | output | 1 | Reinitialization window in progress |

## Verification
The assertions assume that event pulses, valid/ready pairs and lane vectors are synchronous to `clk` and settle before each edge. They also assume that `reg_addr` and `reg_wdata` are stable whenever `reg_wr` is high. The stimulus changes every input only on the falling edge. It draws events sparsely and at random from a fixed seed, so that sticky bits, clears and windows overlap often. Directed cases add the collisions of a clear with a set, triggers inside an active window, and requests that must wait for the window to end.

// File: rtl/lnk_err_pkg.sv
package lnk_err_pkg;
  localparam int ERR_W  = 9;
  localparam int B_LEMC = 0;
  localparam int B_LDAT = 1;
  localparam int B_FDAT = 2;
  localparam int B_CMD  = 3;
  localparam int B_RDY  = 4;
  localparam int B_FULL = 5;
  localparam int B_UNF  = 7;
  localparam int B_OVF  = 8;
  localparam logic [ERR_W-1:0] ERR_MASK = 9'h1BF;
  localparam logic [ERR_W-1:0] IEN_RST  = 9'h1B1;
  localparam logic [ERR_W-1:0] REN_RST  = 9'h000;
  localparam int NUM_HS = 3;
  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_IEN  = 2'd1,
    A_REN  = 2'd2,
    A_CTL  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lnk_err_lane_reduce.sv
module lnk_err_lane_reduce #(
  parameter int NUM_LANES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  input  logic [NUM_LANES-1:0] lane_rdy,
  input  logic [NUM_LANES-1:0] lane_full,
  output logic                 rdy_drop_evt,
  output logic                 full_evt
);
  logic [NUM_LANES-1:0] rdy_q;
  logic [NUM_LANES-1:0] drop_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '0;
    else        rdy_q <= lane_rdy;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign drop_v[g] = rdy_q[g] & ~lane_rdy[g];
  end

  assign rdy_drop_evt = link_up & (|drop_v);
  assign full_evt     = link_up & (|lane_full);
endmodule

// File: rtl/lnk_err_hs_mon.sv
module lnk_err_hs_mon #(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] valid,
  input  logic [NUM_CH-1:0] ready,
  output logic [NUM_CH-1:0] viol
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign viol[g] = ready[g] & ~valid[g];
  end
endmodule

// File: rtl/lnk_err_status.sv
module lnk_err_status
  import lnk_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] evt,
  input  logic             stat_we,
  input  logic             ien_we,
  input  logic             ren_we,
  input  logic [ERR_W-1:0] wdata,
  output logic [ERR_W-1:0] status_q,
  output logic [ERR_W-1:0] ien_q,
  output logic [ERR_W-1:0] ren_q,
  output logic             auto_trig
);
  logic [ERR_W-1:0] clr;
  logic [ERR_W-1:0] status_d;
  logic [ERR_W-1:0] rise;

  assign clr      = stat_we ? (wdata & ERR_MASK) : '0;
  assign status_d = ((status_q & ~clr) | evt) & ERR_MASK;
  assign rise     = evt & ~status_q & ren_q & ERR_MASK;
  assign auto_trig = |rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= IEN_RST;
      ren_q    <= REN_RST;
    end else begin
      status_q <= status_d;
      if (ien_we) ien_q <= wdata & ERR_MASK;
      if (ren_we) ren_q <= wdata & ERR_MASK;
    end
  end
endmodule

// File: rtl/lnk_err_reinit.sv
module lnk_err_reinit #(
  parameter int REINIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_trig,
  input  logic man_set,
  output logic man_pend,
  output logic busy
);
  localparam int CNT_W = (REINIT_CYCLES > 1) ? $clog2(REINIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REINIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign start = !busy && (auto_trig || man_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      man_pend <= 1'b0;
    end else begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= CNT_LOAD;
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
      if (man_set)    man_pend <= 1'b1;
      else if (start) man_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/lnk_err_ctrl.sv
module lnk_err_ctrl
  import lnk_err_pkg::*;
#(
  parameter int NUM_LANES     = 16,
  parameter int REINIT_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  input  logic                 gb_ovf_pulse,
  input  logic                 gb_unf_pulse,
  input  logic                 lemc_err_pulse,
  input  logic                 cmd_valid,
  input  logic                 cmd_ready,
  input  logic                 fdata_valid,
  input  logic                 fdata_ready,
  input  logic                 ldata_valid,
  input  logic                 ldata_ready,
  input  logic [NUM_LANES-1:0] lane_rdy,
  input  logic [NUM_LANES-1:0] lane_full,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [ERR_W-1:0]     reg_wdata,
  output logic [ERR_W-1:0]     reg_rdata,
  output logic                 irq,
  output logic                 reinit_active
);
  logic                 rdy_drop_evt;
  logic                 full_evt;
  logic [NUM_HS-1:0]    hs_valid;
  logic [NUM_HS-1:0]    hs_ready;
  logic [NUM_HS-1:0]    hs_viol;
  logic [ERR_W-1:0]     evt;
  logic [ERR_W-1:0]     status_q;
  logic [ERR_W-1:0]     ien_q;
  logic [ERR_W-1:0]     ren_q;
  logic                 auto_trig;
  logic                 man_pend;
  logic                 busy;
  logic                 stat_we;
  logic                 ien_we;
  logic                 ren_we;
  logic                 man_set;
  reg_addr_e            addr;

  assign addr = reg_addr_e'(reg_addr);

  lnk_err_lane_reduce #(.NUM_LANES(NUM_LANES)) u_lanes (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .lane_rdy     (lane_rdy),
    .lane_full    (lane_full),
    .rdy_drop_evt (rdy_drop_evt),
    .full_evt     (full_evt)
  );

  assign hs_valid = {cmd_valid, fdata_valid, ldata_valid};
  assign hs_ready = {cmd_ready, fdata_ready, ldata_ready};

  lnk_err_hs_mon #(.NUM_CH(NUM_HS)) u_hs (
    .valid (hs_valid),
    .ready (hs_ready),
    .viol  (hs_viol)
  );

  always_comb begin
    evt         = '0;
    evt[B_OVF]  = gb_ovf_pulse;
    evt[B_UNF]  = gb_unf_pulse;
    evt[B_FULL] = full_evt;
    evt[B_RDY]  = rdy_drop_evt;
    evt[B_CMD]  = hs_viol[2];
    evt[B_FDAT] = hs_viol[1];
    evt[B_LDAT] = hs_viol[0];
    evt[B_LEMC] = lemc_err_pulse;
  end

  assign stat_we = reg_wr && (addr == A_STAT);
  assign ien_we  = reg_wr && (addr == A_IEN);
  assign ren_we  = reg_wr && (addr == A_REN);
  assign man_set = reg_wr && (addr == A_CTL) && reg_wdata[0];

  lnk_err_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .stat_we   (stat_we),
    .ien_we    (ien_we),
    .ren_we    (ren_we),
    .wdata     (reg_wdata),
    .status_q  (status_q),
    .ien_q     (ien_q),
    .ren_q     (ren_q),
    .auto_trig (auto_trig)
  );

  lnk_err_reinit #(.REINIT_CYCLES(REINIT_CYCLES)) u_reinit (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_trig (auto_trig),
    .man_set   (man_set),
    .man_pend  (man_pend),
    .busy      (busy)
  );

  always_comb begin
    unique case (addr)
      A_STAT:  reg_rdata = status_q;
      A_IEN:   reg_rdata = ien_q;
      A_REN:   reg_rdata = ren_q;
      default: reg_rdata = {{(ERR_W-2){1'b0}}, busy, man_pend};
    endcase
  end

  assign irq           = |(status_q & ien_q);
  assign reinit_active = busy;
endmodule

// File: rtl/lnk_err_ctrl_chk.sv
module lnk_err_ctrl_chk
  import lnk_err_pkg::*;
#(
  parameter int NUM_LANES     = 16,
  parameter int REINIT_CYCLES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 link_up,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [NUM_LANES-1:0] lane_rdy,
  input logic                 reg_wr,
  input logic [1:0]           reg_addr,
  input logic [ERR_W-1:0]     reg_rdata,
  input logic [ERR_W-1:0]     status_q,
  input logic [ERR_W-1:0]     ien_q,
  input logic                 man_pend,
  input logic                 irq,
  input logic                 reinit_active
);
  localparam int RUN_W = $clog2(REINIT_CYCLES + 2);

  logic [NUM_LANES-1:0] rdy_prev;
  logic [RUN_W-1:0]     busy_run;
  logic                 stat_wr;

  assign stat_wr = reg_wr && (reg_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_prev <= '0;
      busy_run <= '0;
    end else begin
      rdy_prev <= lane_rdy;
      if (reinit_active && busy_run <= RUN_W'(REINIT_CYCLES)) busy_run <= busy_run + 1'b1;
      else if (!reinit_active)                               busy_run <= '0;
    end
  end

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (($past(status_q) & ~status_q) == '0)); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 2'd3) |-> (reg_rdata[6] == 1'b0)); // R3

  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && |(rdy_prev & ~lane_rdy)) |=> status_q[4]); // R4

  AST_CMD_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> status_q[3]); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status_q & ien_q) != '0)); // R8

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RUN_W'(REINIT_CYCLES)); // R9

  AST_MAN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (man_pend && !reinit_active) |=> reinit_active); // R11
endmodule

bind lnk_err_ctrl lnk_err_ctrl_chk #(
  .NUM_LANES     (NUM_LANES),
  .REINIT_CYCLES (REINIT_CYCLES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .link_up       (link_up),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .lane_rdy      (lane_rdy),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .status_q      (status_q),
  .ien_q         (ien_q),
  .man_pend      (man_pend),
  .irq           (irq),
  .reinit_active (reinit_active)
);

// File: tb/lnk_err_ctrl_tb.sv
module lnk_err_ctrl_tb;
  localparam int NL = 16;
  localparam int RC = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, link_up, gb_ovf, gb_unf, lemc;
  logic cmd_valid, cmd_ready, fdata_valid, fdata_ready, ldata_valid, ldata_ready;
  logic [NL-1:0] lane_rdy, lane_full;
  logic reg_wr;
  logic [1:0] reg_addr;
  logic [8:0] reg_wdata, reg_rdata;
  logic irq, reinit_active;

  lnk_err_ctrl #(.NUM_LANES(NL), .REINIT_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .gb_ovf_pulse(gb_ovf), .gb_unf_pulse(gb_unf), .lemc_err_pulse(lemc),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .fdata_valid(fdata_valid), .fdata_ready(fdata_ready),
    .ldata_valid(ldata_valid), .ldata_ready(ldata_ready),
    .lane_rdy(lane_rdy), .lane_full(lane_full),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .reinit_active(reinit_active)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [8:0] m_st, m_ien, m_ren;
  logic m_pend, m_busy;
  int m_cnt;
  logic [NL-1:0] m_rprev;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] m_events();
    logic [8:0] e;
    e = '0;
    e[8] = gb_ovf;
    e[7] = gb_unf;
    e[5] = link_up && (|lane_full);
    e[4] = link_up && (|(m_rprev & ~lane_rdy));
    e[3] = cmd_ready && !cmd_valid;
    e[2] = fdata_ready && !fdata_valid;
    e[1] = ldata_ready && !ldata_valid;
    e[0] = lemc;
    return e;
  endfunction

  function automatic logic [8:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_st;
      2'd1: return m_ien;
      2'd2: return m_ren;
      default: return {7'd0, m_busy, m_pend};
    endcase
  endfunction

  task automatic cyc();
    logic [8:0] e, clr, rise, n_st, n_ien, n_ren;
    logic start, n_pend, n_busy;
    int n_cnt;
    e = m_events();
    clr = (reg_wr && reg_addr == 2'd0) ? (reg_wdata & 9'h1BF) : 9'h0;
    rise = e & ~m_st & m_ren;
    n_st = ((m_st & ~clr) | e) & 9'h1BF;
    n_ien = (reg_wr && reg_addr == 2'd1) ? (reg_wdata & 9'h1BF) : m_ien;
    n_ren = (reg_wr && reg_addr == 2'd2) ? (reg_wdata & 9'h1BF) : m_ren;
    start = !m_busy && ((|rise) || m_pend);
    n_busy = m_busy; n_cnt = m_cnt;
    if (start) begin n_busy = 1'b1; n_cnt = RC - 1; end
    else if (m_busy) begin
      if (m_cnt == 0) n_busy = 1'b0; else n_cnt = m_cnt - 1;
    end
    n_pend = (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) ? 1'b1 : (start ? 1'b0 : m_pend);
    @(posedge clk);
    m_st = n_st; m_ien = n_ien; m_ren = n_ren; m_busy = n_busy; m_cnt = n_cnt;
    m_pend = n_pend; m_rprev = lane_rdy;
    @(negedge clk);
    chk("R8 irq model", {31'd0, irq}, {31'd0, |(m_st & m_ien)});
    chk("R9 window model", {31'd0, reinit_active}, {31'd0, m_busy});
    chk("R1 register model", {23'd0, reg_rdata}, {23'd0, m_read(reg_addr)});
  endtask

  task automatic idle();
    gb_ovf = 0; gb_unf = 0; lemc = 0;
    cmd_valid = 0; cmd_ready = 0; fdata_valid = 0; fdata_ready = 0;
    ldata_valid = 0; ldata_ready = 0; lane_full = '0;
    reg_wr = 0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [8:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    idle();
  endtask

  task automatic rd(logic [1:0] a, output logic [8:0] d);
    reg_wr = 0; reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] d;
    bit restarted;
    bit was_low;
    idle();
    rst_n = 0; link_up = 1; lane_rdy = '1;
    m_st = 0; m_ien = 9'h1B1; m_ren = 0; m_pend = 0; m_busy = 0; m_cnt = 0; m_rprev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); chk("R7 status reset", {23'd0, d}, 32'h000);
    rd(1, d); chk("R7 irq enable reset", {23'd0, d}, 32'h1B1);
    rd(2, d); chk("R7 reinit enable reset", {23'd0, d}, 32'h000);
    rd(3, d); chk("R12 control reset", {23'd0, d}, 32'h000);
    chk("R8 irq reset", {31'd0, irq}, 32'd0);
    m_rprev = lane_rdy;

    // R1 overflow bit
    gb_ovf = 1; cyc(); idle();
    rd(0, d); chk("R1 overflow bit 8", {23'd0, d}, 32'h100);
    chk("R8 irq on enabled bit", {31'd0, irq}, 32'd1);
    // R2 clears
    wr(0, 9'h100); rd(0, d); chk("R2 write one clears", {23'd0, d}, 32'h000);
    gb_unf = 1; cyc(); idle();
    wr(0, 9'h000); rd(0, d); chk("R2 write zero keeps", {23'd0, d}, 32'h080);
    wr(0, 9'h080);
    lemc = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 9'h001; cyc(); idle();
    rd(0, d); chk("R2 set beats clear", {23'd0, d}, 32'h001);
    wr(0, 9'h001);
    // R3 reserved
    wr(1, 9'h1FF); rd(1, d); chk("R3 irq enable bit 6", {23'd0, d}, 32'h1BF);
    wr(2, 9'h040); rd(2, d); chk("R3 reinit enable bit 6", {23'd0, d}, 32'h000);
    wr(3, 9'h1FE); rd(3, d); chk("R3 control upper bits", {23'd0, d}, 32'h000);
    wr(1, 9'h1B1);
    // R4 lane ready drops
    link_up = 0; lane_rdy[7] = 0; cyc(); idle();
    lane_rdy = '1; cyc();
    link_up = 1; cyc();
    rd(0, d); chk("R4 drop or rise ignored", {23'd0, d}, 32'h000);
    lane_rdy[13] = 0; cyc();
    rd(0, d); chk("R4 lane drop sets bit 4", {23'd0, d}, 32'h010);
    wr(0, 9'h010); lane_rdy = '1; cyc();
    // R5 fifo full
    link_up = 0; lane_full[3] = 1; cyc(); idle(); link_up = 1;
    rd(0, d); chk("R5 full ignored link down", {23'd0, d}, 32'h000);
    lane_full[15] = 1; cyc(); idle();
    rd(0, d); chk("R5 full sets bit 5", {23'd0, d}, 32'h020);
    wr(0, 9'h020);
    // R6 handshake
    cmd_ready = 1; cmd_valid = 1; fdata_valid = 1; cyc(); idle();
    rd(0, d); chk("R6 no violation", {23'd0, d}, 32'h000);
    cmd_ready = 1; cyc(); idle();
    rd(0, d); chk("R6 command violation", {23'd0, d}, 32'h008);
    fdata_ready = 1; ldata_ready = 1; cyc(); idle();
    rd(0, d); chk("R6 data violations", {23'd0, d}, 32'h00E);
    wr(0, 9'h00E);
    // R8 masking
    wr(1, 9'h000); lemc = 1; cyc(); idle();
    chk("R8 masked bit no irq", {31'd0, irq}, 32'd0);
    wr(1, 9'h001); chk("R8 enabled bit irq", {31'd0, irq}, 32'd1);
    wr(0, 9'h001); chk("R8 cleared bit no irq", {31'd0, irq}, 32'd0);
    wr(1, 9'h1B1);
    // R9 / R10 automatic window
    wr(2, 9'h180);
    gb_ovf = 1; cyc(); idle();
    chk("R9 window starts", {31'd0, reinit_active}, 32'd1);
    for (int i = 1; i < RC; i++) begin
      if (i == 2) gb_unf = 1;
      cyc(); idle();
      chk("R9 window held", {31'd0, reinit_active}, 32'd1);
    end
    cyc();
    chk("R10 window not extended", {31'd0, reinit_active}, 32'd0);
    cyc();
    chk("R10 no restart", {31'd0, reinit_active}, 32'd0);
    rd(0, d); chk("R10 status still set", {23'd0, d}, 32'h180);
    wr(0, 9'h180); wr(2, 9'h000);
    // R11 / R12 manual request
    wr(3, 9'h001); rd(3, d); chk("R11 request pending", {23'd0, d}, 32'h001);
    cyc(); rd(3, d); chk("R12 window active and request cleared", {23'd0, d}, 32'h002);
    wr(3, 9'h001); rd(3, d); chk("R11 request waits", {23'd0, d}, 32'h003);
    restarted = 0; was_low = 0;
    for (int i = 0; i < 3 * RC; i++) begin
      cyc();
      if (!reinit_active) was_low = 1;
      else if (was_low) restarted = 1;
    end
    chk("R11 deferred start", {31'd0, restarted}, 32'd1);
    rd(3, d); chk("R11 idle after deferred window", {23'd0, d}, 32'h000);

    // random phase
    void'($urandom(32'h1D2C));
    wr(2, 9'h1BF);
    for (int n = 0; n < 4000; n++) begin
      idle();
      gb_ovf = ($urandom % 24) == 0;
      gb_unf = ($urandom % 24) == 0;
      lemc   = ($urandom % 24) == 0;
      if (($urandom % 32) == 0) link_up = ~link_up;
      if (($urandom % 10) == 0) lane_rdy[$urandom % NL] = ~lane_rdy[$urandom % NL];
      if (($urandom % 30) == 0) lane_full[$urandom % NL] = 1;
      {cmd_valid, cmd_ready} = 2'($urandom);
      cmd_valid = cmd_valid | (($urandom % 4) != 0);
      {fdata_valid, fdata_ready} = 2'($urandom);
      fdata_valid = fdata_valid | (($urandom % 4) != 0);
      {ldata_valid, ldata_ready} = 2'($urandom);
      ldata_valid = ldata_valid | (($urandom % 4) != 0);
      if (($urandom % 5) == 0) begin
        reg_wr = 1; reg_addr = 2'($urandom); reg_wdata = 9'($urandom);
      end else begin
        reg_addr = 2'($urandom);
      end
      cyc();
    end
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule